// File: doc/BRIEF.md
# Atomic Interrupt-Disable Instruction Unit

This unit decodes and executes the two-halfword extended instruction that turns interrupts off. A request carries the two halfwords of the instruction, a flag saying whether coprocessor 0 may be used, and the current 32-bit Status word. One cycle later the unit returns a registered result. The result holds the Status write-back with the interrupt-enable bit cleared, and, for the register form, a general-register write of the Status value as it was before the clear. If coprocessor 0 access is refused, the result is a coprocessor-unusable exception. An encoding that does not match is reported as unrecognised.

The Status read and the enable clear come from a single sample of `status_in` and are issued as one write-back. No interrupt or exception can fall between them. The 3-bit compact register field is widened to a full 5-bit register index before use.

The unit keeps a hazard flag. The flag rises with every Status update and falls only when the surrounding pipeline signals a hazard barrier.

A four-state machine classifies each request. `ST_IDLE` means no request was taken. `ST_UPDATE` means a recognised instruction with coprocessor 0 usable. `ST_TRAP` means a recognised instruction with coprocessor 0 refused. `ST_REJECT` means an unrecognised encoding. Each cycle the next state is chosen as follows:
- no `in_valid` leads to `ST_IDLE`;
- otherwise a failed decode leads to `ST_REJECT`;
- otherwise a refused coprocessor leads to `ST_TRAP`;
- otherwise the next state is `ST_UPDATE`.

Every state can reach every other state directly.

Top module: `intdis_unit`

## Requirements
- R1: The instruction is recognised only if the fields match exactly. `instr_hi` must be {11110, 000, 000, op} with fields of 5, 3, 3 and 5 bits, most significant first. `instr_lo` must be {01100, 111, ry, 01100}. Any other value gives `illegal` with no Status write, no register write and no exception.
- R2: Register form, op = 00010: the result asserts `gpr_we`, and `gpr_data` equals `status_in` as sampled with the request, before the clear.
- R3: No-result form, op = 00110 with ry = 000: the result updates Status and leaves `gpr_we` at 0. Op 00110 with any non-zero ry is unrecognised.
- R4: On a Status update, `status_out` equals the sampled `status_in` with bit 0 (interrupt enable) forced to 0. Bits 31..1 are unchanged. `status_we` is 1.
- R5: A recognised instruction with `cp0_usable` = 0 gives `exc_cpu` = 1, `status_we` = 0 and `gpr_we` = 0. An unrecognised encoding reports `illegal` and never `exc_cpu`.
- R6: The register field ry = 0..7 maps to `gpr_idx` = 16, 17, 2, 3, 4, 5, 6, 7.
- R7: `out_valid` is high for exactly one cycle, the cycle after each cycle with `in_valid` high. While a strobe is low, its data output (`status_out`, `gpr_idx`, `gpr_data`) reads 0.
- R8: `hazard_pending` is 1 in the same cycle as each `status_we`. It stays 1 until a cycle with `hazard_clear` high and then reads 0 from the next cycle on. A new Status update in the same cycle as `hazard_clear` keeps it at 1.
- R9: While reset is asserted, and after it is released, `out_valid`, `status_we`, `gpr_we`, `exc_cpu`, `illegal` and `hazard_pending` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A request is present this cycle |
| instr_hi | input | 16 | First instruction halfword |
| instr_lo | input | 16 | Second instruction halfword |
| cp0_usable | input | 1 | Coprocessor 0 access permitted |
| status_in | input | 32 | Current Status word |
| hazard_clear | input | 1 | Hazard barrier executed |
| out_valid | output | 1 | Result present |
| status_we | output | 1 | Status write-back strobe |
| status_out | output | 32 | New Status value |
| gpr_we | output | 1 | General-register write strobe |
| gpr_idx | output | 5 | Translated destination register |
| gpr_data | output | 32 | Status value before the clear |
| exc_cpu | output | 1 | Coprocessor-unusable exception |
| illegal | output | 1 | Encoding not recognised |
| hazard_pending | output | 1 | Status changed, barrier not yet seen |

## Verification
Two functions can act on the hazard flag in the same cycle: a new Status update setting it and a barrier clearing it. The table walk drives `hazard_clear` together with every request. The flag must therefore read 1 after an update and 0 after any other outcome. Directed cases then show that the flag holds across idle cycles without a barrier and drops after a barrier given alone.

// File: rtl/intdis_pkg.sv
package intdis_pkg;

    localparam int XLEN     = 32;
    localparam int HW       = 16;
    localparam int REG_AW   = 5;
    localparam int CREG_W   = 3;
    localparam int IE_BIT   = 0;

    localparam logic [4:0] PFX_EXT   = 5'b11110;
    localparam logic [2:0] MAJ_COP   = 3'b000;
    localparam logic [2:0] SEL_ZERO  = 3'b000;
    localparam logic [4:0] OP_REGRES = 5'b00010;
    localparam logic [4:0] OP_NORES  = 5'b00110;
    localparam logic [4:0] LO_EDGE   = 5'b01100;
    localparam logic [2:0] LO_MID    = 3'b111;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_UPDATE = 2'd1,
        ST_TRAP   = 2'd2,
        ST_REJECT = 2'd3
    } fsm_t;

    typedef enum logic {
        FORM_NORES = 1'b0,
        FORM_REGRES = 1'b1
    } form_t;

endpackage

// File: rtl/intdis_decode.sv
module intdis_decode
    import intdis_pkg::*;
#(
    parameter int HWIDTH = HW,
    parameter int CW     = CREG_W
) (
    input  logic [HWIDTH-1:0] hi,
    input  logic [HWIDTH-1:0] lo,
    output logic              match,
    output form_t             form,
    output logic [CW-1:0]     creg
);
    logic [4:0] f_pfx;
    logic [2:0] f_maj;
    logic [2:0] f_sel;
    logic [4:0] f_op;
    logic [4:0] f_lhead;
    logic [2:0] f_lmid;
    logic [4:0] f_ltail;
    logic       fixed_ok;

    always_comb begin
        f_pfx   = hi[15:11];
        f_maj   = hi[10:8];
        f_sel   = hi[7:5];
        f_op    = hi[4:0];
        f_lhead = lo[15:11];
        f_lmid  = lo[10:8];
        creg    = lo[7:5];
        f_ltail = lo[4:0];

        fixed_ok = (f_pfx == PFX_EXT) && (f_maj == MAJ_COP) &&
                   (f_sel == SEL_ZERO) && (f_lhead == LO_EDGE) &&
                   (f_lmid == LO_MID) && (f_ltail == LO_EDGE);

        form  = FORM_NORES;
        match = 1'b0;
        if (fixed_ok) begin
            if (f_op == OP_REGRES) begin
                form  = FORM_REGRES;
                match = 1'b1;
            end else if (f_op == OP_NORES && creg == '0) begin
                form  = FORM_NORES;
                match = 1'b1;
            end
        end
    end
endmodule

// File: rtl/intdis_regmap.sv
module intdis_regmap
    import intdis_pkg::*;
#(
    parameter int CW = CREG_W,
    parameter int AW = REG_AW
) (
    input  logic [CW-1:0] creg,
    output logic [AW-1:0] freg
);
    always_comb begin
        unique case (creg)
            3'd0:    freg = AW'(16);
            3'd1:    freg = AW'(17);
            default: freg = AW'(creg);
        endcase
    end
endmodule

// File: rtl/intdis_hazard.sv
module intdis_hazard (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clear_i,
    output logic pending_o
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (set_i) begin
            pend_q <= 1'b1;
        end else if (clear_i) begin
            pend_q <= 1'b0;
        end
    end

    assign pending_o = pend_q;
endmodule

// File: rtl/intdis_unit.sv
module intdis_unit
    import intdis_pkg::*;
#(
    parameter int DW = XLEN,
    parameter int AW = REG_AW,
    parameter int IE = IE_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [15:0]   instr_hi,
    input  logic [15:0]   instr_lo,
    input  logic          cp0_usable,
    input  logic [DW-1:0] status_in,
    input  logic          hazard_clear,
    output logic          out_valid,
    output logic          status_we,
    output logic [DW-1:0] status_out,
    output logic          gpr_we,
    output logic [AW-1:0] gpr_idx,
    output logic [DW-1:0] gpr_data,
    output logic          exc_cpu,
    output logic          illegal,
    output logic          hazard_pending
);
    localparam logic [DW-1:0] IE_MASK = DW'(1) << IE;

    fsm_t              state_q, state_d;
    logic              dec_match;
    form_t             dec_form;
    logic [CREG_W-1:0] dec_creg;
    logic [AW-1:0]     map_idx;

    logic [DW-1:0]     snap_q;
    logic [AW-1:0]     idx_q;
    logic              wr_q;

    intdis_decode u_dec (
        .hi    (instr_hi),
        .lo    (instr_lo),
        .match (dec_match),
        .form  (dec_form),
        .creg  (dec_creg)
    );

    intdis_regmap #(.CW(CREG_W), .AW(AW)) u_map (
        .creg (dec_creg),
        .freg (map_idx)
    );

    always_comb begin
        if (!in_valid)
            state_d = ST_IDLE;
        else if (!dec_match)
            state_d = ST_REJECT;
        else if (!cp0_usable)
            state_d = ST_TRAP;
        else
            state_d = ST_UPDATE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
            idx_q  <= '0;
            wr_q   <= 1'b0;
        end else begin
            snap_q <= status_in;
            idx_q  <= map_idx;
            wr_q   <= (dec_form == FORM_REGRES);
        end
    end

    intdis_hazard u_haz (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (state_d == ST_UPDATE),
        .clear_i   (hazard_clear),
        .pending_o (hazard_pending)
    );

    always_comb begin
        out_valid  = 1'b0;
        status_we  = 1'b0;
        status_out = '0;
        gpr_we     = 1'b0;
        gpr_idx    = '0;
        gpr_data   = '0;
        exc_cpu    = 1'b0;
        illegal    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_UPDATE: begin
                out_valid  = 1'b1;
                status_we  = 1'b1;
                status_out = snap_q & ~IE_MASK;
                if (wr_q) begin
                    gpr_we   = 1'b1;
                    gpr_idx  = idx_q;
                    gpr_data = snap_q;
                end
            end
            ST_TRAP: begin
                out_valid = 1'b1;
                exc_cpu   = 1'b1;
            end
            ST_REJECT: begin
                out_valid = 1'b1;
                illegal   = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/intdis_chk.sv
module intdis_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [15:0] instr_hi,
    input logic [15:0] instr_lo,
    input logic        cp0_usable,
    input logic [31:0] status_in,
    input logic        hazard_clear,
    input logic        out_valid,
    input logic        status_we,
    input logic [31:0] status_out,
    input logic        gpr_we,
    input logic [4:0]  gpr_idx,
    input logic [31:0] gpr_data,
    input logic        exc_cpu,
    input logic        illegal,
    input logic        hazard_pending
);
    AST_IE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        status_we |-> !status_out[0]); // R4

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        status_we |-> status_out[31:1] == $past(status_in[31:1])); // R4

    AST_GPR_OLD_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        gpr_we |-> gpr_data == $past(status_in)); // R2

    AST_GPR_WITH_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        gpr_we |-> status_we); // R3

    AST_TRAP_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        exc_cpu |-> (!status_we && !gpr_we)); // R5

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({status_we, exc_cpu, illegal})); // R1

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        gpr_we |-> (gpr_idx inside {5'd16, 5'd17, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7})); // R6

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R7

    AST_VALID_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R7

    AST_HAZ_WITH_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        status_we |-> hazard_pending); // R8

    AST_HAZ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (hazard_pending && !hazard_clear) |=> hazard_pending); // R8

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !hazard_pending)); // R9
endmodule

bind intdis_unit intdis_chk u_chk (.*);

// File: tb/tb_intdis_unit.sv
module tb_intdis_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 17;

    typedef struct packed {
        logic [15:0] hi;
        logic [15:0] lo;
        logic        cp0;
        logic [31:0] st;
        logic        e_sw;
        logic        e_gw;
        logic [4:0]  e_idx;
        logic        e_exc;
        logic        e_ill;
    } vec_t;

    localparam vec_t [NV-1:0] VECS = '{
        '{16'hF002, 16'h670C, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b1, 5'd16, 1'b0, 1'b0},
        '{16'hF002, 16'h672C, 1'b1, 32'h1234_5679, 1'b1, 1'b1, 5'd17, 1'b0, 1'b0},
        '{16'hF002, 16'h674C, 1'b1, 32'h0000_0001, 1'b1, 1'b1, 5'd2,  1'b0, 1'b0},
        '{16'hF002, 16'h676C, 1'b1, 32'hA5A5_A5A5, 1'b1, 1'b1, 5'd3,  1'b0, 1'b0},
        '{16'hF002, 16'h678C, 1'b1, 32'h0F0F_0F0F, 1'b1, 1'b1, 5'd4,  1'b0, 1'b0},
        '{16'hF002, 16'h67AC, 1'b1, 32'h7000_0003, 1'b1, 1'b1, 5'd5,  1'b0, 1'b0},
        '{16'hF002, 16'h67CC, 1'b1, 32'h0000_0000, 1'b1, 1'b1, 5'd6,  1'b0, 1'b0},
        '{16'hF002, 16'h67EC, 1'b1, 32'h8000_0000, 1'b1, 1'b1, 5'd7,  1'b0, 1'b0},
        '{16'hF006, 16'h670C, 1'b1, 32'hDEAD_BEEF, 1'b1, 1'b0, 5'd0,  1'b0, 1'b0},
        '{16'hF006, 16'h672C, 1'b1, 32'h0000_0001, 1'b0, 1'b0, 5'd0,  1'b0, 1'b1},
        '{16'hF002, 16'h678C, 1'b0, 32'h0000_0001, 1'b0, 1'b0, 5'd0,  1'b1, 1'b0},
        '{16'hF006, 16'h670C, 1'b0, 32'h0000_0001, 1'b0, 1'b0, 5'd0,  1'b1, 1'b0},
        '{16'hF003, 16'h670C, 1'b1, 32'h0000_0001, 1'b0, 1'b0, 5'd0,  1'b0, 1'b1},
        '{16'hE002, 16'h670C, 1'b1, 32'h0000_0001, 1'b0, 1'b0, 5'd0,  1'b0, 1'b1},
        '{16'hF102, 16'h670C, 1'b1, 32'h0000_0001, 1'b0, 1'b0, 5'd0,  1'b0, 1'b1},
        '{16'hF002, 16'h670D, 1'b1, 32'h0000_0001, 1'b0, 1'b0, 5'd0,  1'b0, 1'b1},
        '{16'hF002, 16'h770C, 1'b0, 32'h0000_0001, 1'b0, 1'b0, 5'd0,  1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] instr_hi;
    logic [15:0] instr_lo;
    logic        cp0_usable;
    logic [31:0] status_in;
    logic        hazard_clear;
    logic        out_valid;
    logic        status_we;
    logic [31:0] status_out;
    logic        gpr_we;
    logic [4:0]  gpr_idx;
    logic [31:0] gpr_data;
    logic        exc_cpu;
    logic        illegal;
    logic        hazard_pending;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intdis_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .instr_hi(instr_hi), .instr_lo(instr_lo), .cp0_usable(cp0_usable),
        .status_in(status_in), .hazard_clear(hazard_clear),
        .out_valid(out_valid), .status_we(status_we), .status_out(status_out),
        .gpr_we(gpr_we), .gpr_idx(gpr_idx), .gpr_data(gpr_data),
        .exc_cpu(exc_cpu), .illegal(illegal), .hazard_pending(hazard_pending)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        in_valid     = 1'b0;
        instr_hi     = '0;
        instr_lo     = '0;
        cp0_usable   = 1'b0;
        status_in    = '0;
        hazard_clear = 1'b0;
    endtask

    task automatic check_quiet(input string req);
        check({req, " out_valid"}, {31'd0, out_valid}, 32'd0);
        check({req, " strobes"}, {28'd0, status_we, gpr_we, exc_cpu, illegal}, 32'd0);
        check({req, " data zero"}, status_out | gpr_data | {27'd0, gpr_idx}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        in_valid = 1'b1;
        instr_hi = 16'hF002;
        instr_lo = 16'h670C;
        cp0_usable = 1'b1;
        step();
        // R9: quiet while held in reset even with a request present
        check_quiet("R9 in reset");
        check("R9 hazard in reset", {31'd0, hazard_pending}, 32'd0);
        idle_inputs();
        rst_n = 1'b1;
        step();
        check_quiet("R9 after reset");
        check("R9 hazard after reset", {31'd0, hazard_pending}, 32'd0);

        // Table walk: a barrier accompanies every request (R8 coincidence)
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[NV-1-i];
            in_valid     = 1'b1;
            instr_hi     = v.hi;
            instr_lo     = v.lo;
            cp0_usable   = v.cp0;
            status_in    = v.st;
            hazard_clear = 1'b1;
            step();
            idle_inputs();
            check("R7 out_valid", {31'd0, out_valid}, 32'd1);
            check("R4 status_we", {31'd0, status_we}, {31'd0, v.e_sw});
            check("R4 status_out", status_out, v.e_sw ? (v.st & 32'hFFFF_FFFE) : 32'd0);
            check("R2/R3 gpr_we", {31'd0, gpr_we}, {31'd0, v.e_gw});
            check("R6 gpr_idx", {27'd0, gpr_idx}, {27'd0, v.e_idx});
            check("R2 gpr_data", gpr_data, v.e_gw ? v.st : 32'd0);
            check("R5 exc_cpu", {31'd0, exc_cpu}, {31'd0, v.e_exc});
            check("R1 illegal", {31'd0, illegal}, {31'd0, v.e_ill});
            check("R8 hazard vs barrier", {31'd0, hazard_pending}, {31'd0, v.e_sw});
            step();
            check("R7 single-cycle valid", {31'd0, out_valid}, 32'd0);
        end

        // R8: hold across idle cycles, then drop on a lone barrier
        in_valid   = 1'b1;
        instr_hi   = 16'hF006;
        instr_lo   = 16'h670C;
        cp0_usable = 1'b1;
        status_in  = 32'h0000_0101;
        step();
        idle_inputs();
        check("R3 no-result update", {30'd0, status_we, gpr_we}, 32'd2);
        check("R4 no-result status", status_out, 32'h0000_0100);
        check("R8 set with update", {31'd0, hazard_pending}, 32'd1);
        for (int k = 0; k < 5; k++) begin
            step();
            check("R8 hold without barrier", {31'd0, hazard_pending}, 32'd1);
        end
        check_quiet("R7 idle outputs");
        hazard_clear = 1'b1;
        step();
        hazard_clear = 1'b0;
        check("R8 drop on barrier", {31'd0, hazard_pending}, 32'd0);

        // R5: a trap does not set the hazard flag
        in_valid   = 1'b1;
        instr_hi   = 16'hF002;
        instr_lo   = 16'h674C;
        cp0_usable = 1'b0;
        status_in  = 32'hFFFF_FFFF;
        step();
        idle_inputs();
        check("R5 trap only", {28'd0, status_we, gpr_we, exc_cpu, illegal}, 32'd2);
        check("R5 no hazard on trap", {31'd0, hazard_pending}, 32'd0);

        // R7: back-to-back requests, second sees pre-update status from input
        in_valid   = 1'b1;
        instr_hi   = 16'hF002;
        instr_lo   = 16'h676C;
        cp0_usable = 1'b1;
        status_in  = 32'h0000_0011;
        step();
        check("R2 first of pair", gpr_data, 32'h0000_0011);
        status_in = 32'h0000_0010;
        instr_lo  = 16'h672C;
        step();
        idle_inputs();
        check("R7 second of pair valid", {31'd0, out_valid}, 32'd1);
        check("R6 second of pair idx", {27'd0, gpr_idx}, 32'd17);
        check("R2 second of pair data", gpr_data, 32'h0000_0010);

        // R9: reset clears a pending hazard
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        check("R9 reset clears hazard", {31'd0, hazard_pending}, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule